// File: doc/BRIEF.md
# Split-Execute Pipeline Hazard Control

This block makes the interlock and operand-steering decisions for a six-stage in-order integer pipeline. The stages are fetch, decode, two execute stages, memory and writeback. The arithmetic unit is split over the two execute stages, so an arithmetic result and a branch outcome both exist only at the end of the second execute stage. Each cycle the block looks at what every later stage holds: whether the slot is occupied, which register it targets, whether it writes that register, and whether it is a load. It also sees which source registers the decode stage reads. From these it decides four things:
- where each decode operand is taken from;
- whether fetch and decode must hold;
- whether an empty slot must enter the first execute stage;
- whether a taken branch must squash the younger slots.

The block is purely combinational and has no state. Fetch always continues at the next sequential address. A taken branch resolved in the second execute stage therefore finds three wrong-path slots behind it: fetch, decode and the first execute stage. All three are squashed and the fetch address is redirected. When a squash and a hold would both apply, the squash wins, so a discarded instruction never holds the pipeline.

Top module: `split_exec_hazard_ctl`

## Requirements
- R1: When decode holds no valid instruction, both operand selects are 0 (register file) and neither the hold nor the bubble is asserted.
- R2: If a decode source register (nonzero and in use) is written by a valid instruction in the first execute stage, fetch and decode hold and a bubble is inserted. This applies whether or not that instruction is a load.
- R3: If the youngest writer of a used nonzero source is a valid non-load in the second execute stage, that operand's select is 1.
- R4: If the youngest writer is a non-load in the memory stage, the select is 2. If the youngest writer is in writeback, the select is 3.
- R5: When several stages write the same source, the youngest writer decides: second execute first, then memory, then writeback.
- R6: A load in the second execute or memory stage that is the youngest writer of a used source causes a hold and a bubble. A load in writeback is forwarded with select 3.
- R7: Source register 0 never selects a bypass path and never causes a hold.
- R8: A stage whose valid bit or write flag is low is ignored. A source whose use flag is low gets select 0 and causes no hold.
- R9: A taken-branch signal with a valid second execute stage asserts the redirect. It also asserts the annul for each of fetch, decode and the first execute stage that is valid. Without a valid second execute stage, no redirect and no annul is asserted.
- R10: While the redirect is asserted, the hold and the bubble are low and both operand selects are 0.
- R11: The bubble is asserted exactly when the hold is. The hold is asserted exactly when at least one source needs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| if_vld | input | 1 | Fetch slot occupied |
| dec_vld | input | 1 | Decode slot occupied |
| dec_rs1 | input | 5 | First decode source register |
| dec_use1 | input | 1 | First source is read |
| dec_rs2 | input | 5 | Second decode source register |
| dec_use2 | input | 1 | Second source is read |
| e1_vld | input | 1 | First execute slot occupied |
| e1_rd | input | 5 | First execute destination |
| e1_wen | input | 1 | First execute writes a register |
| e1_ld | input | 1 | First execute holds a load |
| e2_vld | input | 1 | Second execute slot occupied |
| e2_rd | input | 5 | Second execute destination |
| e2_wen | input | 1 | Second execute writes a register |
| e2_ld | input | 1 | Second execute holds a load |
| e2_br_taken | input | 1 | Branch in second execute resolved taken |
| mem_vld | input | 1 | Memory slot occupied |
| mem_rd | input | 5 | Memory destination |
| mem_wen | input | 1 | Memory writes a register |
| mem_ld | input | 1 | Memory holds a load |
| wb_vld | input | 1 | Writeback slot occupied |
| wb_rd | input | 5 | Writeback destination |
| wb_wen | input | 1 | Writeback writes a register |
| fwd_a | output | 2 | First operand select: 0 register file, 1 second execute, 2 memory, 3 writeback |
| fwd_b | output | 2 | Second operand select, same encoding |
| stall_fd | output | 1 | Hold fetch and decode |
| bubble_e1 | output | 1 | Insert an empty slot into the first execute stage |
| annul_if | output | 1 | Squash the fetch slot |
| annul_dec | output | 1 | Squash the decode slot |
| annul_e1 | output | 1 | Squash the first execute slot |
| redirect | output | 1 | Steer fetch to the branch target |

## Verification
The block has no state, so a wrong decision shows up at the ports in the same cycle that the stage contents which provoke it are presented.

Some errors would corrupt operands silently:
- a wrong priority between writers shows as a select naming an older stage;
- a missed load interlock shows as select 1 or 2 for a load;
- a lost register-0 guard shows as a bypass or hold on source 0.

A missed squash or a squash that still holds the pipeline shows as the redirect together with a hold or a nonzero select. The bench therefore compares every output against a behavioural model on every cycle, for both directed and randomized stage contents.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned SRC_N     = 2;

    typedef logic [REG_IDX_W-1:0] ridx_t;

    typedef enum logic [1:0] {
        SEL_RF  = 2'd0,
        SEL_EX2 = 2'd1,
        SEL_MEM = 2'd2,
        SEL_WB  = 2'd3
    } opnd_sel_e;

    typedef struct packed {
        logic  live;
        logic  wr;
        logic  ld;
        ridx_t dst;
    } prod_t;

    typedef struct packed {
        logic      need_hold;
        opnd_sel_e sel;
    } src_res_t;

    function automatic logic writes_reg(prod_t p, ridx_t r);
        return p.live && p.wr && (p.dst == r) && (r != '0);
    endfunction

endpackage

// File: rtl/hz_branch_ctl.sv
module hz_branch_ctl (
    input  logic e2_live,
    input  logic taken,
    input  logic if_vld,
    input  logic dec_vld,
    input  logic e1_vld,
    output logic redirect,
    output logic annul_if,
    output logic annul_dec,
    output logic annul_e1
);
    always_comb begin
        redirect  = e2_live && taken;
        annul_if  = redirect && if_vld;
        annul_dec = redirect && dec_vld;
        annul_e1  = redirect && e1_vld;
    end
endmodule

// File: rtl/hz_src_resolve.sv
module hz_src_resolve
    import hz_pkg::*;
(
    input  logic     dec_live,
    input  logic     used,
    input  ridx_t    rs,
    input  prod_t    p_e1,
    input  prod_t    p_e2,
    input  prod_t    p_mem,
    input  prod_t    p_wb,
    output src_res_t res
);
    always_comb begin
        res.need_hold = 1'b0;
        res.sel       = SEL_RF;
        if (dec_live && used && (rs != '0)) begin
            if (writes_reg(p_e1, rs)) begin
                res.need_hold = 1'b1;
            end else if (writes_reg(p_e2, rs)) begin
                if (p_e2.ld) res.need_hold = 1'b1;
                else         res.sel       = SEL_EX2;
            end else if (writes_reg(p_mem, rs)) begin
                if (p_mem.ld) res.need_hold = 1'b1;
                else          res.sel       = SEL_MEM;
            end else if (writes_reg(p_wb, rs)) begin
                res.sel = SEL_WB;
            end
        end
    end
endmodule

// File: rtl/split_exec_hazard_ctl.sv
module split_exec_hazard_ctl
    import hz_pkg::*;
(
    input  logic                 if_vld,
    input  logic                 dec_vld,
    input  logic [REG_IDX_W-1:0] dec_rs1,
    input  logic                 dec_use1,
    input  logic [REG_IDX_W-1:0] dec_rs2,
    input  logic                 dec_use2,
    input  logic                 e1_vld,
    input  logic [REG_IDX_W-1:0] e1_rd,
    input  logic                 e1_wen,
    input  logic                 e1_ld,
    input  logic                 e2_vld,
    input  logic [REG_IDX_W-1:0] e2_rd,
    input  logic                 e2_wen,
    input  logic                 e2_ld,
    input  logic                 e2_br_taken,
    input  logic                 mem_vld,
    input  logic [REG_IDX_W-1:0] mem_rd,
    input  logic                 mem_wen,
    input  logic                 mem_ld,
    input  logic                 wb_vld,
    input  logic [REG_IDX_W-1:0] wb_rd,
    input  logic                 wb_wen,
    output logic [1:0]           fwd_a,
    output logic [1:0]           fwd_b,
    output logic                 stall_fd,
    output logic                 bubble_e1,
    output logic                 annul_if,
    output logic                 annul_dec,
    output logic                 annul_e1,
    output logic                 redirect
);
    prod_t    p_e1, p_e2, p_mem, p_wb;
    ridx_t    src_idx [SRC_N];
    logic     src_use [SRC_N];
    src_res_t src_res [SRC_N];
    logic     dec_live;
    logic     any_hold;

    always_comb begin
        p_e1  = '{live: e1_vld,  wr: e1_wen,  ld: e1_ld,  dst: e1_rd};
        p_e2  = '{live: e2_vld,  wr: e2_wen,  ld: e2_ld,  dst: e2_rd};
        p_mem = '{live: mem_vld, wr: mem_wen, ld: mem_ld, dst: mem_rd};
        p_wb  = '{live: wb_vld,  wr: wb_wen,  ld: 1'b0,   dst: wb_rd};
        src_idx[0] = dec_rs1;
        src_idx[1] = dec_rs2;
        src_use[0] = dec_use1;
        src_use[1] = dec_use2;
    end

    hz_branch_ctl u_br (
        .e2_live   (e2_vld),
        .taken     (e2_br_taken),
        .if_vld    (if_vld),
        .dec_vld   (dec_vld),
        .e1_vld    (e1_vld),
        .redirect  (redirect),
        .annul_if  (annul_if),
        .annul_dec (annul_dec),
        .annul_e1  (annul_e1)
    );

    // Squash outranks hold: a decode slot being discarded never interlocks.
    assign dec_live = dec_vld && !redirect;

    for (genvar s = 0; s < SRC_N; s++) begin : g_src
        hz_src_resolve u_res (
            .dec_live (dec_live),
            .used     (src_use[s]),
            .rs       (src_idx[s]),
            .p_e1     (p_e1),
            .p_e2     (p_e2),
            .p_mem    (p_mem),
            .p_wb     (p_wb),
            .res      (src_res[s])
        );
    end

    always_comb begin
        any_hold = 1'b0;
        for (int s = 0; s < SRC_N; s++) any_hold = any_hold | src_res[s].need_hold;
    end

    assign stall_fd  = any_hold;
    assign bubble_e1 = any_hold;
    assign fwd_a     = src_res[0].sel;
    assign fwd_b     = src_res[1].sel;

endmodule

// File: rtl/hz_ctl_checker.sv
module hz_ctl_checker
    import hz_pkg::*;
(
    input logic                 dec_vld,
    input logic [REG_IDX_W-1:0] dec_rs1,
    input logic                 dec_use1,
    input logic [REG_IDX_W-1:0] dec_rs2,
    input logic                 dec_use2,
    input logic                 e1_vld,
    input logic [REG_IDX_W-1:0] e1_rd,
    input logic                 e1_wen,
    input logic [1:0]           fwd_a,
    input logic [1:0]           fwd_b,
    input logic                 stall_fd,
    input logic                 bubble_e1,
    input logic                 annul_if,
    input logic                 annul_dec,
    input logic                 annul_e1,
    input logic                 redirect
);
    always_comb begin
        a_r10_squash_beats_hold: assert (!(redirect && (stall_fd || fwd_a != 2'd0 || fwd_b != 2'd0)));
        a_r11_bubble_with_hold: assert (bubble_e1 == stall_fd);
        a_r9_annul_only_on_redirect: assert (redirect || !(annul_if || annul_dec || annul_e1));
        a_r7_zero_src_a: assert (dec_rs1 != '0 || fwd_a == 2'd0);
        a_r7_zero_src_b: assert (dec_rs2 != '0 || fwd_b == 2'd0);
        a_r8_unused_src: assert ((dec_use1 || fwd_a == 2'd0) && (dec_use2 || fwd_b == 2'd0));
        a_r1_empty_decode: assert (dec_vld || !(stall_fd || fwd_a != 2'd0 || fwd_b != 2'd0));
        if (dec_vld && !redirect && dec_use1 && dec_rs1 != '0 && e1_vld && e1_wen && e1_rd == dec_rs1) begin
            a_r2_exe1_dep_holds: assert (stall_fd);
        end
    end
endmodule

bind split_exec_hazard_ctl hz_ctl_checker u_chk (.*);

// File: tb/tb_split_exec_hazard_ctl.sv
module tb_split_exec_hazard_ctl;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_P/2) clk = ~clk;

    logic       if_vld, dec_vld, dec_use1, dec_use2, e2_br_taken;
    logic [4:0] dec_rs1, dec_rs2;
    logic       e1_vld, e1_wen, e1_ld, e2_vld, e2_wen, e2_ld;
    logic       mem_vld, mem_wen, mem_ld, wb_vld, wb_wen;
    logic [4:0] e1_rd, e2_rd, mem_rd, wb_rd;
    logic [1:0] fwd_a, fwd_b;
    logic       stall_fd, bubble_e1, annul_if, annul_dec, annul_e1, redirect;

    split_exec_hazard_ctl dut (.*);

    // stimulus model: index 0 first execute, 1 second execute, 2 memory, 3 writeback
    bit s_v[4]; int s_rd[4]; bit s_w[4]; bit s_l[4];
    bit m_if, m_dec, m_u1, m_u2, m_br; int m_rs1, m_rs2;

    int total = 0;
    int bad   = 0;

    task automatic drive();
        if_vld = m_if; dec_vld = m_dec; dec_use1 = m_u1; dec_use2 = m_u2;
        dec_rs1 = 5'(m_rs1); dec_rs2 = 5'(m_rs2); e2_br_taken = m_br;
        e1_vld = s_v[0]; e1_rd = 5'(s_rd[0]); e1_wen = s_w[0]; e1_ld = s_l[0];
        e2_vld = s_v[1]; e2_rd = 5'(s_rd[1]); e2_wen = s_w[1]; e2_ld = s_l[1];
        mem_vld = s_v[2]; mem_rd = 5'(s_rd[2]); mem_wen = s_w[2]; mem_ld = s_l[2];
        wb_vld = s_v[3]; wb_rd = 5'(s_rd[3]); wb_wen = s_w[3];
    endtask

    task automatic clear();
        for (int k = 0; k < 4; k++) begin s_v[k] = 0; s_rd[k] = 0; s_w[k] = 0; s_l[k] = 0; end
        m_if = 0; m_dec = 0; m_u1 = 0; m_u2 = 0; m_br = 0; m_rs1 = 0; m_rs2 = 0;
    endtask

    task automatic setp(int k, int rd, bit ld);
        s_v[k] = 1; s_w[k] = 1; s_rd[k] = rd; s_l[k] = ld;
    endtask

    // behavioural model: scan stages youngest first for one source
    task automatic model_src(input bit live, input bit used, input int rs, output int sel, output bit hold);
        sel = 0; hold = 0;
        if (live && used && rs != 0) begin
            for (int k = 0; k < 4; k++) begin
                if (s_v[k] && s_w[k] && s_rd[k] == rs) begin
                    if (k == 0 || (k < 3 && s_l[k])) hold = 1;
                    else sel = k;
                    break;
                end
            end
        end
    endtask

    task automatic cmp(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // apply current model, then compare every output away from the edge
    task automatic step(string tag);
        bit rdr, live, h1, h2; int s1, s2;
        @(posedge clk); #1; drive();
        rdr  = s_v[1] && m_br;
        live = m_dec && !rdr;
        model_src(live, m_u1, m_rs1, s1, h1);
        model_src(live, m_u2, m_rs2, s2, h2);
        @(negedge clk);
        cmp(tag, "fwd_a", int'(fwd_a), s1);
        cmp(tag, "fwd_b", int'(fwd_b), s2);
        cmp(tag, "stall_fd", int'(stall_fd), int'(h1 | h2));
        cmp({tag, "/R11"}, "bubble_e1", int'(bubble_e1), int'(h1 | h2));
        cmp(tag, "redirect", int'(redirect), int'(rdr));
        cmp(tag, "annul_if", int'(annul_if), int'(rdr && m_if));
        cmp(tag, "annul_dec", int'(annul_dec), int'(rdr && m_dec));
        cmp(tag, "annul_e1", int'(annul_e1), int'(rdr && s_v[0]));
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear(); drive();
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // R1: reset/empty state
        step("R1");
        setp(1, 4, 0); m_u1 = 1; m_rs1 = 4; step("R1");
        // R2: dependency on first execute, alu and load
        clear(); m_dec = 1; m_u1 = 1; m_rs1 = 5; setp(0, 5, 0); step("R2");
        s_l[0] = 1; step("R2");
        // R3: second execute alu bypass
        clear(); m_dec = 1; m_u1 = 1; m_rs1 = 5; setp(1, 5, 0); step("R3");
        // R4: memory and writeback bypass
        clear(); m_dec = 1; m_u1 = 1; m_rs1 = 5; m_u2 = 1; m_rs2 = 6;
        setp(2, 6, 0); setp(3, 5, 0); step("R4");
        // R5: youngest writer wins
        clear(); m_dec = 1; m_u1 = 1; m_rs1 = 7; m_u2 = 1; m_rs2 = 7;
        setp(1, 7, 0); setp(2, 7, 0); setp(3, 7, 0); step("R5");
        s_v[1] = 0; step("R5");
        // R6: load interlocks and writeback load bypass
        clear(); m_dec = 1; m_u2 = 1; m_rs2 = 9; setp(1, 9, 1); step("R6");
        clear(); m_dec = 1; m_u2 = 1; m_rs2 = 9; setp(2, 9, 1); setp(3, 9, 0); step("R6");
        clear(); m_dec = 1; m_u2 = 1; m_rs2 = 9; setp(3, 9, 1); step("R6");
        // R7: register zero
        clear(); m_dec = 1; m_u1 = 1; m_u2 = 1; setp(0, 0, 0); setp(1, 0, 0); step("R7");
        // R8: disabled producers and unused sources
        clear(); m_dec = 1; m_u1 = 1; m_rs1 = 3; setp(0, 3, 0); s_w[0] = 0; step("R8");
        s_w[0] = 1; s_v[0] = 0; setp(2, 3, 0); s_v[2] = 0; step("R8");
        clear(); m_dec = 1; m_rs1 = 3; m_rs2 = 3; setp(0, 3, 0); setp(1, 3, 0); step("R8");
        // R9 / R10: taken branch squashes three slots, overrides hold
        clear(); m_if = 1; m_dec = 1; m_u1 = 1; m_rs1 = 2; setp(0, 2, 0); setp(1, 8, 0);
        m_br = 1; step("R10");
        clear(); m_if = 1; m_dec = 1; m_u1 = 1; m_rs1 = 2; setp(2, 2, 0); setp(1, 8, 0);
        m_br = 1; step("R10");
        clear(); m_if = 1; m_dec = 1; m_br = 1; setp(0, 1, 0); step("R9");
        // randomized contents, small register range to force overlap
        for (int n = 0; n < 400; n++) begin
            clear();
            for (int k = 0; k < 4; k++) begin
                s_v[k] = bit'($urandom_range(0, 1)); s_w[k] = bit'($urandom_range(0, 1));
                s_l[k] = bit'($urandom_range(0, 1)); s_rd[k] = int'($urandom_range(0, 3));
            end
            m_if = bit'($urandom_range(0, 1)); m_dec = bit'($urandom_range(0, 1));
            m_u1 = bit'($urandom_range(0, 1)); m_u2 = bit'($urandom_range(0, 1));
            m_rs1 = int'($urandom_range(0, 3)); m_rs2 = int'($urandom_range(0, 3));
            m_br = ($urandom_range(0, 3) == 0);
            step("R5");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule